// File: doc/BRIEF.md
# Mirrored-Bank Register File with Two Read Ports

This block is a register file for a simple integer datapath. It offers two independent read ports and one write port. The storage consists of two identical banks, each with a single read port. Each bank holds a complete copy of every register. Read port A is served by the first bank and read port B by the second. Every write goes into both banks on the same clock edge, so the two copies always hold the same contents.

Reads are combinational from the address. A forwarding multiplexer on each read port returns the incoming write data when the read address equals an active write address. A datapath can therefore read an operand in the same cycle in which that operand is written. Register 0 is hardwired to zero. After reset, every other register holds a recognisable poison pattern instead of zero, so reads of registers that were never written stand out. The register count is a parameter. It is 32 for the full integer base set and 16 for the reduced embedded set.

Top module: `dup_regfile`

## Requirements
- R1: Each read port is served by its own bank, and each bank holds all registers. After every register has been written with a distinct value, port A and port B each return the correct value for every address.
- R2: When `wr_en` is 1 and `wr_addr` is nonzero, `wr_data` is committed to that register in both banks on the rising clock edge. From the next cycle on, both ports return the new value.
- R3: When both read addresses name the same register, `rd_data_a` and `rd_data_b` are equal.
- R4: When `wr_en` is 1 and a read address equals a nonzero `wr_addr`, that read port returns `wr_data` in the same cycle, in place of the stored value.
- R5: When `wr_en` is 0, no register changes and no forwarding occurs, whatever `wr_addr` and `wr_data` carry.
- R6: Address 0 reads as 32'h0 on both ports. Writes to address 0 are discarded, and address 0 is never forwarded.
- R7: While `rst_n` is 0, every register from 1 to NUM_REGS-1 in both banks is loaded with the sentinel 32'hDEADBEEF. Reset is asynchronous and active-low.
- R8: Read data follows a change of read address within the same cycle, with no clock edge in between.
- R9: NUM_REGS may be 16 or 32. The address width is log2(NUM_REGS), so it is 4 bits for 16 registers, and register NUM_REGS-1 is fully usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, loads the sentinel |
| rd_addr_a | input | AW | Read address, port A |
| rd_data_a | output | DATA_W | Read data, port A (served by bank 0) |
| rd_addr_b | input | AW | Read address, port B |
| rd_data_b | output | DATA_W | Read data, port B (served by bank 1) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address |
| wr_data | input | DATA_W | Write data |

## Verification
The bench instantiates the block twice. The first instance has NUM_REGS = 32 and carries the vector table, the full-register sweep and the reset replay. The second has NUM_REGS = 16 and a 4-bit address. It shows that the reduced configuration decodes its top register and receives the poison fill. With both sizes in use, the address-width derivation and the loop bounds of the banks are exercised at both of their legal settings.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Poison pattern loaded at reset so that reads of unwritten registers stand out.
  localparam logic [31:0] RF_POISON = 32'hDEADBEEF;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } rf_side_e;

  localparam int RF_SIDES = 2;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int              NUM_REGS = 32,
  parameter int              DATA_W   = 32,
  parameter logic [DATA_W-1:0] SENTINEL = '0,
  localparam int             AW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem_q   [1:NUM_REGS-1];
  logic [DATA_W-1:0] mem_nxt [1:NUM_REGS-1];
  logic              load    [1:NUM_REGS-1];

  // Entry 0 has no storage. Each entry gets its own explicit clock enable.
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_entry
    always_comb begin
      load[i]    = wr_en && (wr_addr == AW'(i));
      mem_nxt[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= SENTINEL;
      end else if (load[i]) begin
        mem_q[i] <= mem_nxt[i];
      end
    end
  end

  // Single read port, combinational; address 0 yields zero here.
  always_comb begin
    rd_word = '0;
    for (int j = 1; j < NUM_REGS; j++) begin
      if (rd_addr == AW'(j)) rd_word = mem_q[j];
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |=> (mem_q[$past(wr_addr)] == $past(wr_data))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_addr != '0) |=> (mem_q[$past(rd_addr)] == $past(rd_word))); // R5

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int  DATA_W = 32,
  parameter int  AW     = 5
) (
  input  logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] bank_word,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic is_zero;
  logic fwd;

  always_comb begin
    is_zero = (rd_addr == '0);
    fwd     = wr_en && (wr_addr == rd_addr) && !is_zero;
    if (is_zero) begin
      rd_data = '0;
    end else if (fwd) begin
      rd_data = wr_data;
    end else begin
      rd_data = bank_word;
    end
  end

endmodule

// File: rtl/dup_regfile.sv
module dup_regfile #(
  parameter int                NUM_REGS = 32,
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] SENTINEL = DATA_W'(rf_pkg::RF_POISON),
  localparam int               AW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int SIDES = rf_pkg::RF_SIDES;

  logic [AW-1:0]     side_addr [SIDES];
  logic [DATA_W-1:0] side_word [SIDES];
  logic [DATA_W-1:0] side_data [SIDES];

  always_comb begin
    side_addr[rf_pkg::SIDE_A] = rd_addr_a;
    side_addr[rf_pkg::SIDE_B] = rd_addr_b;
    rd_data_a = side_data[rf_pkg::SIDE_A];
    rd_data_b = side_data[rf_pkg::SIDE_B];
  end

  // One mirrored bank and one forwarding mux per read side.
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    rf_bank #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .SENTINEL (SENTINEL)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (side_addr[s]),
      .rd_word (side_word[s])
    );

    rf_read_port #(
      .DATA_W (DATA_W),
      .AW     (AW)
    ) u_port (
      .rd_addr   (side_addr[s]),
      .bank_word (side_word[s]),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_data   (side_data[s])
    );
  end

  AST_SIDES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b)); // R3

  AST_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_data)); // R4

  AST_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data)); // R4

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0)); // R6

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |=>
      ($stable(rd_addr_b) && !wr_en) |-> (rd_data_b == $past(wr_data))); // R2

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !$past(wr_en) && $stable(rd_addr_a)) |-> $stable(rd_data_a)); // R5

endmodule

// File: tb/dup_regfile_tb.sv
module dup_regfile_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd0,  32'h0,        5'd5,  5'd5,  32'hDEADBEEF, 32'hDEADBEEF}, // R7 R3
    '{1'b1, 5'd5,  32'h11111111, 5'd5,  5'd6,  32'h11111111, 32'hDEADBEEF}, // R4
    '{1'b0, 5'd0,  32'h0,        5'd5,  5'd5,  32'h11111111, 32'h11111111}, // R2 R3
    '{1'b1, 5'd0,  32'hFFFFFFFF, 5'd0,  5'd0,  32'h0,        32'h0},        // R6
    '{1'b0, 5'd0,  32'h0,        5'd0,  5'd5,  32'h0,        32'h11111111}, // R6
    '{1'b0, 5'd6,  32'h22222222, 5'd6,  5'd6,  32'hDEADBEEF, 32'hDEADBEEF}, // R5
    '{1'b0, 5'd0,  32'h0,        5'd6,  5'd31, 32'hDEADBEEF, 32'hDEADBEEF}, // R5
    '{1'b1, 5'd31, 32'hA5A5A5A5, 5'd30, 5'd31, 32'hDEADBEEF, 32'hA5A5A5A5}, // R4
    '{1'b1, 5'd5,  32'h33333333, 5'd31, 5'd5,  32'hA5A5A5A5, 32'h33333333}, // R2 R4
    '{1'b0, 5'd0,  32'h0,        5'd5,  5'd31, 32'h33333333, 32'hA5A5A5A5}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ra = '0, rb = '0, wa = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] qa, qb;

  logic [3:0]  s_ra = '0, s_rb = '0, s_wa = '0;
  logic        s_we = 1'b0;
  logic [31:0] s_wd = '0;
  logic [31:0] s_qa, s_qb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dup_regfile #(.NUM_REGS(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(ra), .rd_data_a(qa),
    .rd_addr_b(rb), .rd_data_b(qb),
    .wr_en(we), .wr_addr(wa), .wr_data(wd)
  );

  dup_regfile #(.NUM_REGS(16)) u_dut_small (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(s_ra), .rd_data_a(s_qa),
    .rd_addr_b(s_rb), .rd_data_b(s_qb),
    .wr_en(s_we), .wr_addr(s_wa), .wr_data(s_wd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i) << 24) | 32'h00C30000 | (32'(i) << 8) | 32'h3C;
  endfunction

  initial begin
    // Reset, released at a falling edge.
    repeat (3) @(negedge clk);
    #1;
    ra = 5'd9; rb = 5'd0;
    #1;
    check("R7 reset poison A", qa, 32'hDEADBEEF);
    check("R6 reset zero B", qb, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: drive after negedge, compare before the next posedge.
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      we = VECS[k].we; wa = VECS[k].wa; wd = VECS[k].wd;
      ra = VECS[k].ra; rb = VECS[k].rb;
      #1;
      check($sformatf("vec%0d port A (R2-R7 table)", k), qa, VECS[k].ea);
      check($sformatf("vec%0d port B (R2-R7 table)", k), qb, VECS[k].eb);
    end

    // R8: address change with no clock edge in between.
    @(negedge clk);
    we = 1'b0; ra = 5'd31; rb = 5'd6;
    #1;
    check("R8 port A before change", qa, 32'hA5A5A5A5);
    ra = 5'd5;
    #1;
    check("R8 port A after change", qa, 32'h33333333);
    check("R8 port B", qb, 32'hDEADBEEF);

    // R1: fill every register, then read A ascending and B descending.
    for (int i = 1; i < 32; i++) begin
      @(negedge clk);
      we = 1'b1; wa = 5'(i); wd = pat(i);
    end
    @(negedge clk);
    we = 1'b0;
    for (int i = 0; i < 32; i++) begin
      ra = 5'(i); rb = 5'(31 - i);
      #1;
      check($sformatf("R1 bank A reg %0d", i), qa, (i == 0) ? 32'h0 : pat(i));
      check($sformatf("R1 bank B reg %0d", 31 - i), qb, (i == 31) ? 32'h0 : pat(31 - i));
    end

    // R5: disabled write with full-looking payload changes nothing.
    @(negedge clk);
    we = 1'b0; wa = 5'd12; wd = 32'h0BADF00D; ra = 5'd12; rb = 5'd12;
    #1;
    check("R5 no forward when disabled", qa, pat(12));
    @(negedge clk);
    #1;
    check("R5 no commit when disabled", qb, pat(12));

    // R7: reset mid-run reloads the poison, register 0 stays zero.
    @(negedge clk);
    #2 rst_n = 1'b0;
    ra = 5'd7; rb = 5'd0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 reload reg7", qa, 32'hDEADBEEF);
    check("R7 reg0 after reload", qb, 32'h0);

    // R9: 16-entry instance with 4-bit addresses.
    @(negedge clk);
    s_ra = 4'd15; s_rb = 4'd15;
    #1;
    check("R9 small poison top reg", s_qa, 32'hDEADBEEF);
    s_we = 1'b1; s_wa = 4'd15; s_wd = 32'h0F0F0F0F;
    @(negedge clk);
    s_we = 1'b0;
    #1;
    check("R9 small top reg A", s_qa, 32'h0F0F0F0F);
    check("R9 small top reg B", s_qb, 32'h0F0F0F0F);
    s_ra = 4'd14;
    #1;
    check("R9 small neighbour untouched", s_qa, 32'hDEADBEEF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule